// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block is a clocked model of a true dual-port memory. It has two independent ports, left and right, and each can read or write any word. Each port has a two-pin chip select, a read/write strobe, an output enable, an address and write data. Read data comes out through a registered stage, one clock after the request. The two ports may target the same word in the same cycle.

A same-address access raises a busy flag toward the port that loses, and that port's write is dropped. A mode input sets the role of the busy lines. As the master, the block drives its busy outputs from its own arbiter. As the slave, it drives its busy outputs low and takes busy from a partner device, so that ganged devices act on one decision when words are made wider. Depth and width are parameters, and the default is small.

Top module: `dpram_arb`

## Requirements
- R1: A port is selected only while its active-low select `*_ce0_n` is 0 and its active-high select `*_ce1` is 1. A port that is not selected writes nothing, reads nothing and asserts no read-data enable.
- R2: When a selected port has `*_rw_n`=1 and `*_oe_n`=0, the next cycle shows the word at the requested address on `*_rdata`, with `*_rdata_oe`=1. The word is the content from before any write made in the request cycle.
- R3: After reset, and in the cycle after any cycle with no read request on a port, that port has `*_rdata_oe`=0 and `*_rdata`=0.
- R4: A selected port with `*_rw_n`=0 writes `*_wdata` at the clock edge. Writes from both ports to different addresses in the same cycle both take effect.
- R5: An arbitration busy is raised only when both ports are selected with equal addresses. Busy is never raised toward both ports at once.
- R6: Master mode, new contention: when both ports reach the same address and neither port held that address in the previous cycle, the right port gets busy and its write is dropped. The left port proceeds.
- R7: Master mode, incumbent: when the right port was selected at an address in the previous cycle and the left port was not, a left arrival there gets busy and its write is dropped. The same winner is kept while the contention stays on that address.
- R8: In master mode the `*_busy_in` inputs have no effect on writes.
- R9: In slave mode (`master_sel`=0) both `*_busy_out` are 0. An asserted `*_busy_in` drops that port's write, but its read still returns array data.
- R10: In slave mode with no busy input, when both ports write one address in the same cycle, the left data is stored.
- R11: A port that is not selected never gets busy and never causes busy on the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 1: arbitration drives busy; 0: busy taken from inputs |
| l_ce0_n | input | 1 | Left select, active low |
| l_ce1 | input | 1 | Left select, active high |
| l_rw_n | input | 1 | Left strobe: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data (0 when disabled) |
| l_rdata_oe | output | 1 | Left read data driven |
| l_busy_in | input | 1 | Left busy from a master (slave mode) |
| l_busy_out | output | 1 | Left busy from arbitration (master mode) |
| r_ce0_n | input | 1 | Right select, active low |
| r_ce1 | input | 1 | Right select, active high |
| r_rw_n | input | 1 | Right strobe: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data (0 when disabled) |
| r_rdata_oe | output | 1 | Right read data driven |
| r_busy_in | input | 1 | Right busy from a master (slave mode) |
| r_busy_out | output | 1 | Right busy from arbitration (master mode) |

## Verification
The case that is hardest to reach from the ports is the incumbent right port. The left port must lose on the same address, and this happens only when the right port held that address alone in the previous cycle. The bench first parks the right port on a pre-written word for one cycle with the left port idle. It then brings the left port in with a write, checks busy before the edge, and confirms through a later read that the word did not change. It then keeps both ports on that address for another cycle to check that the right port stays the winner.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;

    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
    } port_ctl_t;

    typedef enum logic {
        WIN_LEFT  = 1'b0,
        WIN_RIGHT = 1'b1
    } winner_e;

    function automatic port_ctl_t decode_ctl(input logic ce0_n, input logic ce1,
                                             input logic rw_n, input logic oe_n);
        port_ctl_t c;
        c.sel = ~ce0_n & ce1;
        c.wr  = c.sel & ~rw_n;
        c.rd  = c.sel & rw_n & ~oe_n;
        return c;
    endfunction

endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel,
    input  logic              r_sel,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              busy_l,
    output logic              busy_r
);

    logic              prev_l_sel, prev_r_sel;
    logic [ADDR_W-1:0] prev_l_addr, prev_r_addr;
    logic              cont_q;
    logic [ADDR_W-1:0] cont_addr_q;
    winner_e           own_q;

    logic    hit;
    winner_e win;
    logic    r_incumbent, l_incumbent;

    always_comb begin
        hit         = l_sel & r_sel & (l_addr == r_addr);
        r_incumbent = prev_r_sel & (prev_r_addr == l_addr);
        l_incumbent = prev_l_sel & (prev_l_addr == l_addr);
        if (cont_q && (cont_addr_q == l_addr))
            win = own_q;
        else if (r_incumbent && !l_incumbent)
            win = WIN_RIGHT;
        else
            win = WIN_LEFT;
        busy_l = hit & (win == WIN_RIGHT);
        busy_r = hit & (win == WIN_LEFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_l_sel  <= 1'b0;
            prev_r_sel  <= 1'b0;
            prev_l_addr <= '0;
            prev_r_addr <= '0;
            cont_q      <= 1'b0;
            cont_addr_q <= '0;
            own_q       <= WIN_LEFT;
        end else begin
            prev_l_sel  <= l_sel;
            prev_r_sel  <= r_sel;
            prev_l_addr <= l_addr;
            prev_r_addr <= r_addr;
            cont_q      <= hit;
            cont_addr_q <= l_addr;
            own_q       <= win;
        end
    end

endmodule

// File: rtl/dpram_core.sv
module dpram_core #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              we_l,
    input  logic              we_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wd_l,
    input  logic [DATA_W-1:0] wd_r,
    output logic [DATA_W-1:0] rd_l,
    output logic [DATA_W-1:0] rd_r
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_l = mem[addr_l];
    assign rd_r = mem[addr_r];

    // Right first so that a same-word double write keeps the left data.
    always_ff @(posedge clk) begin
        if (we_r) mem[addr_r] <= wd_r;
        if (we_l) mem[addr_l] <= wd_l;
    end

endmodule

// File: rtl/dpram_rd_stage.sv
module dpram_rd_stage #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    always_ff @(posedge clk) begin
        if (rst || !rd_en) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else begin
            dout    <= din;
            dout_oe <= 1'b1;
        end
    end

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_sel,
    input  logic              l_ce0_n,
    input  logic              l_ce1,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rdata_oe,
    input  logic              l_busy_in,
    output logic              l_busy_out,
    input  logic              r_ce0_n,
    input  logic              r_ce1,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rdata_oe,
    input  logic              r_busy_in,
    output logic              r_busy_out
);

    port_ctl_t         ctl      [NUM_PORTS];
    logic [DATA_W-1:0] arr_rd   [NUM_PORTS];
    logic [DATA_W-1:0] rdata    [NUM_PORTS];
    logic              rdata_oe [NUM_PORTS];
    logic              raw_busy [NUM_PORTS];
    logic              busy_in  [NUM_PORTS];
    logic              blk      [NUM_PORTS];
    logic              we       [NUM_PORTS];

    always_comb begin
        ctl[PORT_L]     = decode_ctl(l_ce0_n, l_ce1, l_rw_n, l_oe_n);
        ctl[PORT_R]     = decode_ctl(r_ce0_n, r_ce1, r_rw_n, r_oe_n);
        busy_in[PORT_L] = l_busy_in;
        busy_in[PORT_R] = r_busy_in;
    end

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .l_sel  (ctl[PORT_L].sel),
        .r_sel  (ctl[PORT_R].sel),
        .l_addr (l_addr),
        .r_addr (r_addr),
        .busy_l (raw_busy[PORT_L]),
        .busy_r (raw_busy[PORT_R])
    );

    dpram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk    (clk),
        .we_l   (we[PORT_L]),
        .we_r   (we[PORT_R]),
        .addr_l (l_addr),
        .addr_r (r_addr),
        .wd_l   (l_wdata),
        .wd_r   (r_wdata),
        .rd_l   (arr_rd[PORT_L]),
        .rd_r   (arr_rd[PORT_R])
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign blk[p] = master_sel ? raw_busy[p] : busy_in[p];
        assign we[p]  = ctl[p].wr & ~blk[p];

        dpram_rd_stage #(.DATA_W(DATA_W)) u_rd (
            .clk     (clk),
            .rst     (rst),
            .rd_en   (ctl[p].rd),
            .din     (arr_rd[p]),
            .dout    (rdata[p]),
            .dout_oe (rdata_oe[p])
        );
    end

    assign l_rdata    = rdata[PORT_L];
    assign r_rdata    = rdata[PORT_R];
    assign l_rdata_oe = rdata_oe[PORT_L];
    assign r_rdata_oe = rdata_oe[PORT_R];
    assign l_busy_out = master_sel & raw_busy[PORT_L];
    assign r_busy_out = master_sel & raw_busy[PORT_R];

endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              master_sel,
    input logic              l_ce0_n,
    input logic              l_ce1,
    input logic              l_rw_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_ce0_n,
    input logic              r_ce1,
    input logic              r_rw_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_rdata_oe,
    input logic              r_rdata_oe,
    input logic              l_busy_out,
    input logic              r_busy_out
);

    logic lsel, rsel, same, seen;
    assign lsel = ~l_ce0_n & l_ce1;
    assign rsel = ~r_ce0_n & r_ce1;
    assign same = (l_addr == r_addr);

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    AST_BUSY_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        !(l_busy_out && r_busy_out)); // R5

    AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (l_busy_out || r_busy_out) |-> (lsel && rsel && same)); // R5

    AST_SLAVE_BUSY_LOW: assert property (@(posedge clk) disable iff (rst)
        !master_sel |-> (!l_busy_out && !r_busy_out)); // R9

    AST_DESEL_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!lsel || !rsel) |-> (!l_busy_out && !r_busy_out)); // R11

    AST_L_RD_OFF: assert property (@(posedge clk) disable iff (rst)
        !(lsel && l_rw_n && !l_oe_n) |=> !l_rdata_oe); // R3

    AST_R_RD_ON: assert property (@(posedge clk) disable iff (rst)
        (rsel && r_rw_n && !r_oe_n) |=> r_rdata_oe); // R2

    AST_NEW_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
        (seen && master_sel && lsel && rsel && same && !$past(lsel) && !$past(rsel))
        |-> (r_busy_out && !l_busy_out)); // R6

    AST_RIGHT_INCUMBENT: assert property (@(posedge clk) disable iff (rst)
        (seen && master_sel && lsel && rsel && same && !$past(lsel) && $past(rsel)
         && ($past(r_addr) == l_addr)) |-> l_busy_out); // R7

endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .master_sel (master_sel),
    .l_ce0_n    (l_ce0_n),
    .l_ce1      (l_ce1),
    .l_rw_n     (l_rw_n),
    .l_oe_n     (l_oe_n),
    .l_addr     (l_addr),
    .r_ce0_n    (r_ce0_n),
    .r_ce1      (r_ce1),
    .r_rw_n     (r_rw_n),
    .r_oe_n     (r_oe_n),
    .r_addr     (r_addr),
    .l_rdata_oe (l_rdata_oe),
    .r_rdata_oe (r_rdata_oe),
    .l_busy_out (l_busy_out),
    .r_busy_out (r_busy_out)
);

// File: tb/dpram_arb_tb.sv
`timescale 1ns/1ps
module dpram_arb_tb;

    localparam int AW = 5;
    localparam int DW = 9;

    logic          clk = 1'b0;
    logic          rst;
    logic          master_sel;
    logic          l_ce0_n, l_ce1, l_rw_n, l_oe_n, l_busy_in;
    logic [AW-1:0] l_addr;
    logic [DW-1:0] l_wdata;
    logic [DW-1:0] l_rdata;
    logic          l_rdata_oe, l_busy_out;
    logic          r_ce0_n, r_ce1, r_rw_n, r_oe_n, r_busy_in;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_wdata;
    logic [DW-1:0] r_rdata;
    logic          r_rdata_oe, r_busy_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .master_sel(master_sel),
        .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rdata_oe(l_rdata_oe),
        .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
        .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rdata_oe(r_rdata_oe),
        .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drv_l(input logic c0n, input logic c1, input logic rwn, input logic oen,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_ce0_n = c0n; l_ce1 = c1; l_rw_n = rwn; l_oe_n = oen; l_addr = a; l_wdata = d;
    endtask

    task automatic drv_r(input logic c0n, input logic c1, input logic rwn, input logic oen,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_ce0_n = c0n; r_ce1 = c1; r_rw_n = rwn; r_oe_n = oen; r_addr = a; r_wdata = d;
    endtask

    task automatic idle_l(); drv_l(1'b1, 1'b0, 1'b1, 1'b1, '0, '0); endtask
    task automatic idle_r(); drv_r(1'b1, 1'b0, 1'b1, 1'b1, '0, '0); endtask
    task automatic wr_l(input logic [AW-1:0] a, input logic [DW-1:0] d); drv_l(1'b0, 1'b1, 1'b0, 1'b1, a, d); endtask
    task automatic wr_r(input logic [AW-1:0] a, input logic [DW-1:0] d); drv_r(1'b0, 1'b1, 1'b0, 1'b1, a, d); endtask
    task automatic rd_l(input logic [AW-1:0] a); drv_l(1'b0, 1'b1, 1'b1, 1'b0, a, '0); endtask
    task automatic rd_r(input logic [AW-1:0] a); drv_r(1'b0, 1'b1, 1'b1, 1'b0, a, '0); endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic t_reset();
        master_sel = 1'b1; l_busy_in = 1'b0; r_busy_in = 1'b0;
        idle_l(); idle_r();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R3 reset l_rdata_oe", l_rdata_oe, 0);
        chk("R3 reset l_rdata", l_rdata, 0);
        chk("R3 reset r_rdata_oe", r_rdata_oe, 0);
        chk("R5 reset busy", {l_busy_out, r_busy_out}, 0);
    endtask

    task automatic t_rw();
        wr_l(5'd3, 9'h101); wr_r(5'd4, 9'h0AB);
        settle();
        chk("R5 different addr no busy", {l_busy_out, r_busy_out}, 0);
        tick();
        rd_l(5'd4); rd_r(5'd3);
        tick();
        chk("R2 l_rdata_oe", l_rdata_oe, 1);
        chk("R4 l reads right write", l_rdata, 9'h0AB);
        chk("R4 r reads left write", r_rdata, 9'h101);
        idle_l(); idle_r();
        tick();
        chk("R3 idle l_rdata_oe", l_rdata_oe, 0);
        chk("R3 idle r_rdata", r_rdata, 0);
    endtask

    task automatic t_select();
        wr_l(5'd5, 9'h011); tick();
        drv_l(1'b1, 1'b1, 1'b0, 1'b1, 5'd5, 9'h1FF); tick();
        drv_l(1'b0, 1'b0, 1'b0, 1'b1, 5'd5, 9'h1EE); tick();
        rd_l(5'd5); tick();
        chk("R1 deselected writes dropped", l_rdata, 9'h011);
        drv_l(1'b1, 1'b1, 1'b1, 1'b0, 5'd5, '0); tick();
        chk("R1 deselected read oe", l_rdata_oe, 0);
        chk("R1 deselected read data", l_rdata, 0);
        drv_l(1'b0, 1'b1, 1'b1, 1'b1, 5'd5, '0); tick();
        chk("R3 oe_n high no data", {l_rdata_oe, l_rdata}, 0);
        idle_l(); tick();
    endtask

    task automatic t_tie();
        idle_l(); idle_r(); tick();
        wr_l(5'd7, 9'h0AA); wr_r(5'd7, 9'h055);
        settle();
        chk("R6 tie right busy", r_busy_out, 1);
        chk("R6 tie left not busy", l_busy_out, 0);
        tick();
        idle_r(); rd_l(5'd7); tick();
        chk("R6 right write dropped", l_rdata, 9'h0AA);
        idle_l(); tick();
        wr_l(5'd8, 9'h0C3); tick();
        idle_l(); tick();
        wr_l(5'd8, 9'h03C); rd_r(5'd8); tick();
        chk("R2 read sees pre-write word", r_rdata, 9'h0C3);
        idle_r(); rd_l(5'd8); tick();
        chk("R6 winner write lands", l_rdata, 9'h03C);
        idle_l(); tick();
    endtask

    task automatic t_incumbent();
        wr_l(5'd9, 9'h012); tick();
        idle_l(); tick();
        rd_r(5'd9); tick();
        rd_r(5'd9); wr_l(5'd9, 9'h033);
        settle();
        chk("R7 late left busy", l_busy_out, 1);
        chk("R7 incumbent right free", r_busy_out, 0);
        tick();
        chk("R7 incumbent read", r_rdata, 9'h012);
        wr_r(5'd9, 9'h044); wr_l(5'd9, 9'h066);
        settle();
        chk("R7 winner held", {l_busy_out, r_busy_out}, 2'b10);
        tick();
        idle_r(); rd_l(5'd9); tick();
        chk("R7 left write dropped", l_rdata, 9'h044);
        idle_l(); tick();
    endtask

    task automatic t_master_busy_in();
        master_sel = 1'b1; l_busy_in = 1'b1; r_busy_in = 1'b1;
        wr_l(5'd12, 9'h0F0);
        settle();
        chk("R8 busy_out unaffected", l_busy_out, 0);
        tick();
        rd_l(5'd12); tick();
        chk("R8 busy_in ignored in master", l_rdata, 9'h0F0);
        l_busy_in = 1'b0; r_busy_in = 1'b0;
        idle_l(); tick();
    endtask

    task automatic t_slave();
        master_sel = 1'b0;
        idle_l(); idle_r(); tick();
        wr_l(5'd14, 9'h141); wr_r(5'd14, 9'h092);
        settle();
        chk("R9 slave busy_out low", {l_busy_out, r_busy_out}, 0);
        tick();
        idle_r(); rd_l(5'd14); tick();
        chk("R10 slave double write keeps left", l_rdata, 9'h141);
        idle_l(); wr_r(5'd15, 9'h010); tick();
        r_busy_in = 1'b1;
        wr_r(5'd15, 9'h021); tick();
        rd_r(5'd15); tick();
        chk("R9 busy_in blocks write, read works", r_rdata, 9'h010);
        chk("R9 read oe under busy_in", r_rdata_oe, 1);
        r_busy_in = 1'b0; master_sel = 1'b1;
        idle_r(); tick();
    endtask

    task automatic t_desel();
        idle_l(); idle_r(); tick();
        wr_l(5'd20, 9'h0D0); drv_r(1'b1, 1'b1, 1'b0, 1'b1, 5'd20, 9'h0E0);
        settle();
        chk("R11 ce0 high no busy", {l_busy_out, r_busy_out}, 0);
        tick();
        wr_l(5'd20, 9'h0D1); drv_r(1'b0, 1'b0, 1'b0, 1'b1, 5'd20, 9'h0E1);
        settle();
        chk("R11 ce1 low no busy", {l_busy_out, r_busy_out}, 0);
        tick();
        idle_r(); rd_l(5'd20); tick();
        chk("R11 left write completes", l_rdata, 9'h0D1);
        idle_l(); tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_rw();
        t_select();
        t_tie();
        t_incumbent();
        t_master_busy_in();
        t_slave();
        t_desel();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule